// File: doc/BRIEF.md
# Receive-Side DMA Burst Write Engine

This block moves received frame data out of a DWord-wide FIFO into a host memory buffer. It is given the buffer's byte address and its exact length, and then works as a bus master. It raises a request, waits for grant, and issues one address phase with a memory-write command. It then streams DWord data phases taken from the FIFO head. The first and last DWords of a buffer that starts or ends off a DWord boundary get active-low byte enables. These enables mask the lanes that lie outside the buffer.

A burst stops in three cases:
- the FIFO drains to a programmable low watermark;
- the last DWord of the buffer has been written;
- the grant has been removed and a latency down-counter has reached zero.

Grant removal alone does not end a burst. The engine keeps the bus until the latency counter expires. Between bursts the engine waits until the FIFO holds more DWords than the watermark, or holds every DWord still owed to the buffer. When the buffer is complete it pulses done and reports the exact byte length, not the rounded DWord amount.

The FIFO must present its data already placed in the byte lanes of the destination address. The watermark and latency inputs are expected to stay stable while a transfer is running.

Top module: `rx_burst_dma`

## Requirements
- R1: When grant is seen while requesting, the next cycle is an address phase. In that cycle frame_o is 1, irdy_o is 0, cbe_o is 4'b0111, and ad_o is the buffer address rounded down to a DWord plus 4 times the number of DWords already written.
- R2: In every data phase irdy_o is 1 and ad_o equals the FIFO head word. fifo_rd_o is 1 exactly when irdy_o and trdy_i are both 1. A phase with trdy_i low is repeated unchanged.
- R3: cbe_o in a data phase is active low, one bit per byte lane. In the first DWord, the lanes below the start offset (buf_addr_i[1:0]) are disabled. In the last DWord, the lanes above the end offset ((offset+length-1) mod 4) are disabled. Every other DWord drives 4'b0000. A single-DWord buffer applies both masks, so offset 1 gives 4'b0001 and end offset 0 gives 4'b1110.
- R4: Every data phase moves a full DWord. The number of completed data phases per transfer is ceil((offset+length)/4).
- R5: While fewer DWords are queued than remain, a data phase that starts with fifo_count_i at most low_wm_i+1 is the last of its burst, so the FIFO is left at the watermark.
- R6: The data phase carrying the buffer's final DWord is always the last of its burst.
- R7: On the grant edge the latency counter loads lat_init_i. It then decrements every clock, saturating at 0, so in the k-th data cycle of a burst it holds max(L-k,0). While gnt_i is 0, frame_o stays 1 until that value is 0. It is dropped in the first data cycle with gnt_i 0 and an expired counter.
- R8: Once frame_o has dropped in a burst it stays low: frame_o is 0 in the final data phase while irdy_o is 1, one clock before irdy_o falls.
- R9: A burst is requested only when fifo_count_i > low_wm_i, or when fifo_count_i is at least the number of DWords still owed. Otherwise req_o stays 0.
- R10: done_o pulses for one cycle exactly two clocks after the final data phase completes, with byte_cnt_o equal to buf_len_i.
- R11: After reset req_o, frame_o, irdy_o, fifo_rd_o and done_o are 0 and cbe_o is 4'b1111.
- R12: The cycle after a burst's final data phase has frame_o, irdy_o and req_o all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (ignored while busy) |
| buf_addr_i | input | 32 | Buffer start byte address |
| buf_len_i | input | 16 | Buffer length in bytes, at least 1 |
| low_wm_i | input | 8 | FIFO low watermark in DWords |
| lat_init_i | input | 8 | Latency counter load value |
| fifo_data_i | input | 32 | FIFO head DWord |
| fifo_count_i | input | 8 | DWords held in the FIFO |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| req_o | output | 1 | Bus request |
| gnt_i | input | 1 | Bus grant |
| frame_o | output | 1 | Transaction in progress, high true |
| irdy_o | output | 1 | Master data ready, high true |
| trdy_i | input | 1 | Target data accepted, high true |
| ad_o | output | 32 | Address or data |
| cbe_o | output | 4 | Command in address phase, active-low byte enables in data phases |
| done_o | output | 1 | Transfer complete pulse |
| byte_cnt_o | output | 16 | Exact byte count of the transfer |

## Verification
A wrong DWord index or remaining count shows at once in the ad_o of the next address phase. It also shows in the byte enables of the first or last data phase, and it shifts the done pulse off its two-cycle slot. A stuck stop flag or a latency counter that is off by one cycle moves the frame_o drop by at least one data phase. That drop is compared every data cycle against a model built from the live FIFO count, the grant and the cycles since the grant. A lost or extra FIFO pop makes ad_o differ from the expected word sequence on the very next data phase.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_TURN
  } rxd_state_e;

  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/rxd_addr_track.sv
module rxd_addr_track #(
  parameter int AD_W  = 32,
  parameter int LEN_W = 16,
  localparam int BE_W  = AD_W / 8,
  localparam int OFF_W = $clog2(BE_W),
  localparam int REM_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AD_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             adv_i,
  output logic [AD_W-1:0]  cur_addr_o,
  output logic [REM_W-1:0] rem_o,
  output logic             first_o,
  output logic             last_o,
  output logic [OFF_W-1:0] off_o,
  output logic [OFF_W-1:0] end_off_o
);
  logic [AD_W-1:0]  base_q;
  logic [REM_W-1:0] idx_q, rem_q;
  logic [OFF_W-1:0] off_q, eo_q;
  logic [REM_W-1:0] span;

  assign span = REM_W'(len_i) + REM_W'(base_i[OFF_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      off_q  <= '0;
      eo_q   <= '0;
    end else if (load_i) begin
      base_q <= {base_i[AD_W-1:OFF_W], {OFF_W{1'b0}}};
      off_q  <= base_i[OFF_W-1:0];
      eo_q   <= OFF_W'(span - REM_W'(1));
      rem_q  <= (span + REM_W'(BE_W - 1)) >> OFF_W;
      idx_q  <= '0;
    end else if (adv_i) begin
      idx_q <= idx_q + REM_W'(1);
      rem_q <= rem_q - REM_W'(1);
    end
  end

  assign cur_addr_o = base_q + (AD_W'(idx_q) << OFF_W);
  assign rem_o      = rem_q;
  assign first_o    = (idx_q == '0);
  assign last_o     = (rem_q == REM_W'(1));
  assign off_o      = off_q;
  assign end_off_o  = eo_q;

  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (rem_q != '0));
endmodule

// File: rtl/rxd_be_gen.sv
module rxd_be_gen #(
  parameter int BE_W = 4,
  localparam int OFF_W = $clog2(BE_W)
) (
  input  logic             first_i,
  input  logic             last_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W-1:0] end_off_i,
  output logic [BE_W-1:0]  cbe_no
);
  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    logic lo_ok, hi_ok;
    assign lo_ok     = !first_i || (OFF_W'(l) >= off_i);
    assign hi_ok     = !last_i  || (OFF_W'(l) <= end_off_i);
    assign cbe_no[l] = !(lo_ok && hi_ok);
  end
endmodule

// File: rtl/rxd_lat_timer.sv
module rxd_lat_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] val_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - LAT_W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rx_burst_dma.sv
module rx_burst_dma
  import rxd_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int LEN_W = 16,
  parameter int CNT_W = 8,
  parameter int LAT_W = 8,
  localparam int BE_W  = AD_W / 8,
  localparam int OFF_W = $clog2(BE_W),
  localparam int REM_W = LEN_W + 1,
  localparam int CMP_W = ((CNT_W > REM_W) ? CNT_W : REM_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AD_W-1:0]  buf_addr_i,
  input  logic [LEN_W-1:0] buf_len_i,
  input  logic [CNT_W-1:0] low_wm_i,
  input  logic [LAT_W-1:0] lat_init_i,
  input  logic [AD_W-1:0]  fifo_data_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  output logic             fifo_rd_o,
  output logic             req_o,
  input  logic             gnt_i,
  output logic             frame_o,
  output logic             irdy_o,
  input  logic             trdy_i,
  output logic [AD_W-1:0]  ad_o,
  output logic [BE_W-1:0]  cbe_o,
  output logic             done_o,
  output logic [LEN_W-1:0] byte_cnt_o
);
  rxd_state_e state_q, state_d;
  logic             stop_q, stop_c;
  logic [LEN_W-1:0] len_q;
  logic [AD_W-1:0]  cur_addr;
  logic [REM_W-1:0] rem;
  logic             first_dw, last_dw;
  logic [OFF_W-1:0] off, end_off;
  logic [BE_W-1:0]  be_n;
  logic             lat_expired, lat_load;
  logic [CMP_W-1:0] cnt_x, lw_x, rem_x;
  logic             above_wm, have_tail, wm_hit;
  logic             load;

  assign cnt_x     = CMP_W'(fifo_count_i);
  assign lw_x      = CMP_W'(low_wm_i);
  assign rem_x     = CMP_W'(rem);
  assign above_wm  = cnt_x > lw_x;
  assign have_tail = cnt_x >= rem_x;
  assign wm_hit    = (cnt_x <= lw_x + CMP_W'(1)) && !have_tail;

  assign load     = (state_q == S_IDLE) && start_i;
  assign lat_load = (state_q == S_REQ) && gnt_i;

  // final phase of a burst; sticky via stop_q so frame never reasserts
  assign stop_c = stop_q || last_dw || wm_hit || (!gnt_i && lat_expired);

  rxd_addr_track #(.AD_W(AD_W), .LEN_W(LEN_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .base_i     (buf_addr_i),
    .len_i      (buf_len_i),
    .adv_i      (fifo_rd_o),
    .cur_addr_o (cur_addr),
    .rem_o      (rem),
    .first_o    (first_dw),
    .last_o     (last_dw),
    .off_o      (off),
    .end_off_o  (end_off)
  );

  rxd_be_gen #(.BE_W(BE_W)) u_be (
    .first_i   (first_dw),
    .last_i    (last_dw),
    .off_i     (off),
    .end_off_i (end_off),
    .cbe_no    (be_n)
  );

  rxd_lat_timer #(.LAT_W(LAT_W)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (lat_load),
    .val_i     (lat_init_i),
    .run_i     (state_q == S_ADDR || state_q == S_DATA),
    .expired_o (lat_expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_WAIT;
      S_WAIT: begin
        if (rem == '0)                  state_d = S_IDLE;
        else if (above_wm || have_tail) state_d = S_REQ;
      end
      S_REQ:  if (gnt_i) state_d = S_ADDR;
      S_ADDR: state_d = S_DATA;
      S_DATA: if (trdy_i && stop_c) state_d = S_TURN;
      S_TURN: state_d = S_WAIT;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      stop_q  <= 1'b0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load) len_q <= buf_len_i;
      if (state_q == S_ADDR)      stop_q <= 1'b0;
      else if (state_q == S_DATA) stop_q <= stop_c;
    end
  end

  always_comb begin
    ad_o  = '0;
    cbe_o = '1;
    unique case (state_q)
      S_ADDR: begin
        ad_o  = cur_addr;
        cbe_o = CMD_MEM_WR;
      end
      S_DATA: begin
        ad_o  = fifo_data_i;
        cbe_o = be_n;
      end
      default: ;
    endcase
  end

  assign req_o      = (state_q == S_REQ);
  assign frame_o    = (state_q == S_ADDR) || (state_q == S_DATA && !stop_c);
  assign irdy_o     = (state_q == S_DATA);
  assign fifo_rd_o  = (state_q == S_DATA) && trdy_i;
  assign done_o     = (state_q == S_WAIT) && (rem == '0);
  assign byte_cnt_o = len_q;

  a_r8_frame_before_irdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_o) |-> irdy_o);

  a_r12_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_o && !frame_o) |=> (!irdy_o && !frame_o && !req_o));

  a_r2_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irdy_o && !trdy_i) |=> (irdy_o && $stable(cbe_o)));

  a_r1_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && !irdy_o) |-> ($past(gnt_i) && $past(req_o)));
endmodule

// File: tb/rx_burst_dma_bench.sv
module rx_burst_dma_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] buf_addr_i = '0;
  logic [15:0] buf_len_i = '0;
  logic [7:0]  low_wm_i = '0;
  logic [7:0]  lat_init_i = '0;
  logic [31:0] fifo_data_i;
  logic [7:0]  fifo_count_i;
  logic        fifo_rd_o, req_o, frame_o, irdy_o, done_o;
  logic        gnt_i = 1'b0;
  logic        trdy_i = 1'b0;
  logic [31:0] ad_o;
  logic [3:0]  cbe_o;
  logic [15:0] byte_cnt_o;

  always #2.5 clk_i = ~clk_i;

  rx_burst_dma u_rx_burst_dma (
    .clk_i, .rst_ni, .start_i, .buf_addr_i, .buf_len_i, .low_wm_i, .lat_init_i,
    .fifo_data_i, .fifo_count_i, .fifo_rd_o, .req_o, .gnt_i, .frame_o, .irdy_o,
    .trdy_i, .ad_o, .cbe_o, .done_o, .byte_cnt_o
  );

  logic [31:0] fifo_mem [0:4095];
  int wr = 0, rd = 0, wr_idx = 0;
  assign fifo_count_i = 8'(wr - rd);
  assign fifo_data_i  = (wr > rd) ? fifo_mem[rd[11:0]] : 32'h0;

  int n_chk = 0, n_err = 0, cycles = 0;
  bit timeout = 0;
  int t_total, t_len, t_off, t_eo, t_lat, t_lw, idx, k, fin_cnt = -1;
  logic [31:0] t_base_al, salt;
  bit stop_seen, end_prev, xfer_done;
  int push_pct, gnt_pct, trdy_pct, drop_k;

  function automatic logic [31:0] word(int i);
    return 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203) ^ salt;
  endfunction

  function automatic logic [3:0] exp_be(int i);
    logic [3:0] m = 4'hF;
    if (i == 0) m = m & (4'hF << t_off);
    if (i == t_total - 1) m = m & (4'hF >> (3 - t_eo));
    return ~m;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_word();
    fifo_mem[wr[11:0]] = word(wr_idx);
    wr++;
    wr_idx++;
  endtask

  task automatic step();
    int cnt, rem;
    bit complete, reason, exp_stop;
    string tag;
    @(negedge clk_i);
    cycles++;
    if (cycles > 150000) timeout = 1;
    cnt = wr - rd;
    rem = t_total - idx;
    complete = 0;
    chk(fifo_rd_o == (irdy_o && trdy_i), "R2", "fifo_rd", 32'(fifo_rd_o), 32'(irdy_o && trdy_i));
    if (end_prev) begin
      chk(!irdy_o && !frame_o && !req_o, "R12", "bus release", {frame_o, irdy_o, req_o}, 0);
      end_prev = 0;
    end
    if (frame_o && !irdy_o) begin
      chk(ad_o == t_base_al + 32'(4 * idx), "R1", "address", ad_o, t_base_al + 32'(4 * idx));
      chk(cbe_o == 4'b0111, "R1", "command", 32'(cbe_o), 32'h7);
      chk(cnt > t_lw || cnt >= rem, "R9", "burst start fill", cnt, rem);
      k = 0;
      stop_seen = 0;
    end else if (irdy_o) begin
      k++;
      reason = (rem == 1) || (cnt <= t_lw + 1 && cnt < rem) || (!gnt_i && k >= t_lat);
      exp_stop = stop_seen || reason;
      tag = (rem == 1) ? "R6" : (cnt <= t_lw + 1 && cnt < rem) ? "R5" :
            (!gnt_i) ? "R7" : "R8";
      chk(frame_o == !exp_stop, tag, "frame", 32'(frame_o), 32'(!exp_stop));
      chk(ad_o == word(idx), "R2", "data", ad_o, word(idx));
      chk(cbe_o == exp_be(idx), "R3", "byte enables", 32'(cbe_o), 32'(exp_be(idx)));
      stop_seen = exp_stop;
      if (trdy_i) begin
        complete = 1;
        idx++;
        if (exp_stop) begin
          end_prev = 1;
          if (idx == t_total) fin_cnt = -2;
        end
      end
    end
    if (fin_cnt == -2) fin_cnt = 0;
    else if (fin_cnt >= 0) fin_cnt++;
    chk(done_o == (fin_cnt == 2), "R10", "done timing", 32'(done_o), 32'(fin_cnt == 2));
    if (done_o) begin
      chk(byte_cnt_o == 16'(t_len), "R10", "byte count", 32'(byte_cnt_o), t_len);
      chk(idx == t_total, "R4", "dword phases", idx, t_total);
      xfer_done = 1;
    end
    if (fin_cnt == 2) fin_cnt = -1;
    @(posedge clk_i);
    #1;
    start_i = 1'b0;
    if (complete) rd++;
    if (!frame_o && !irdy_o && wr_idx < t_total && ($urandom % 100) < push_pct) push_word();
    trdy_i = ($urandom % 100) < trdy_pct;
    if (drop_k >= 0) gnt_i = !(irdy_o && k + 1 >= drop_k);
    else gnt_i = ($urandom % 100) < gnt_pct;
  endtask

  task automatic run_xfer(logic [31:0] addr, int len, int lat, int lw, int pre,
                          int pp, int gp, int tp, int dk, int hold);
    int guard;
    t_base_al = {addr[31:2], 2'b00};
    t_off = int'(addr[1:0]);
    t_len = len;
    t_total = (t_off + len + 3) / 4;
    t_eo = (t_off + len - 1) % 4;
    t_lat = lat;
    t_lw = lw;
    salt = $urandom;
    idx = 0;
    xfer_done = 0;
    wr = 0; rd = 0; wr_idx = 0;
    for (int i = 0; i < pre && wr_idx < t_total; i++) push_word();
    push_pct = (hold > 0) ? 0 : pp;
    gnt_pct = gp; trdy_pct = tp; drop_k = dk;
    buf_addr_i = addr;
    buf_len_i = 16'(len);
    lat_init_i = 8'(lat);
    low_wm_i = 8'(lw);
    start_i = 1'b1;
    step();
    for (int i = 0; i < hold; i++) begin
      step();
      chk(!req_o, "R9", "request below watermark", 32'(req_o), 0);
    end
    push_pct = pp;
    guard = 0;
    while (!xfer_done && !timeout && guard < 5000) begin
      step();
      guard++;
    end
    if (!xfer_done && !timeout) chk(0, "R10", "transfer never completed", 0, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    t_total = 0; t_lw = 0; t_lat = 0; idx = 0; k = 0;
    push_pct = 0; gnt_pct = 100; trdy_pct = 100; drop_k = -1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!req_o && !frame_o && !irdy_o && !fifo_rd_o && !done_o, "R11", "reset outputs",
        {req_o, frame_o, irdy_o, fifo_rd_o, done_o}, 0);
    chk(cbe_o == 4'hF, "R11", "reset cbe", 32'(cbe_o), 32'hF);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R3 offset 1 start, end offset 2
    run_xfer(32'h1000_0001, 10, 8, 0, 999, 100, 100, 100, -1, 0);
    // R3 single DWord, end offset 0
    run_xfer(32'h2000_0010, 1, 8, 0, 999, 100, 100, 100, -1, 0);
    // R3 single byte in lane 3
    run_xfer(32'h2000_0023, 1, 8, 0, 999, 100, 100, 70, -1, 0);
    // R3 offset 1 start, end offset 0
    run_xfer(32'h3000_0101, 12, 8, 0, 999, 100, 100, 100, -1, 0);
    // R5 watermark-limited bursts
    run_xfer(32'h4000_0000, 64, 20, 4, 8, 50, 100, 100, -1, 0);
    // R7 grant removed early, latency counter 3
    run_xfer(32'h5000_0000, 80, 3, 0, 999, 0, 100, 100, 2, 0);
    // R7 grant removed, counter already zero
    run_xfer(32'h5100_0002, 40, 0, 0, 999, 0, 100, 100, 1, 0);
    // R9 stays idle with only watermark worth of data
    run_xfer(32'h6000_0000, 40, 10, 4, 4, 80, 100, 100, -1, 20);
    for (int n = 0; n < 30 && !timeout; n++) begin
      run_xfer($urandom, 1 + int'($urandom % 200), int'($urandom % 16), int'($urandom % 7),
               ($urandom % 2) ? 999 : 0, 30 + int'($urandom % 61), 60 + int'($urandom % 41),
               40 + int'($urandom % 61), -1, 0);
    end
    if (timeout) chk(0, "R10", "watchdog expired", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule